// File: doc/BRIEF.md
# Supply Rail Window Monitor

The block watches a modelled supply rail and raises two flags: one for over-voltage and one for under-voltage. Software-visible register inputs give a nominal rail voltage in millivolts and a tolerance window width in millivolts. Two inputs stand in for real sensing:

- an injected-noise magnitude;
- load percentages reported by five on-chip test engines.

All inputs are sampled on the rising edge of a dedicated sampling clock. Both flags are registered.

The window is centred on the nominal voltage and spans half the tolerance on each side. Noise larger than half the tolerance pushes the rail past both edges of the window. Such noise therefore raises both flags. A heavy average load sags the rail, so it raises the under-voltage flag only. The load is heavy when the five engines average more than 70 percent.

Once raised, a flag holds its value. Software clears both flags by programming a nominal voltage of zero. The reset input is asynchronous and active low. Its release is expected to arrive already aligned to the sampling clock.

Top module: `rail_window_monitor`

## Requirements
- R1: While `rst_ni` is low, `over_o` and `under_o` are 0, with no clock edge needed. After release, both stay 0 until a set condition from R2, R3 or R5 is sampled.
- R2: At a rising edge where `ref_mv_i` is nonzero and `noise_i` exceeds `tol_mv_i` shifted right by one (truncated), `over_o` is 1 after that edge.
- R3: The same condition as R2 also makes `under_o` 1 after that edge.
- R4: A noise value equal to the truncated half-tolerance sets neither flag. For example, with a tolerance of 9, a noise of 4 sets nothing and a noise of 5 sets both flags.
- R5: At an edge where `ref_mv_i` is nonzero and the five load values sum to more than 350, `under_o` becomes 1 and `over_o` is unaffected. A sum of exactly 350 sets nothing.
- R6: Load lane k is `usage_i[7k+6:7k]`, with lane 0 in the least significant bits. A lane value above 100 counts as 100 in the sum.
- R7: A flag that is 1 stays 1 at every edge where `ref_mv_i` is nonzero, even after its cause has gone.
- R8: At an edge where `ref_mv_i` is 0, both flags become 0. This clear wins over any set condition sampled at the same edge.
- R9: `over_o` is never 1 while `under_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock; all inputs are evaluated on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_mv_i | input | 16 | Nominal rail voltage in mV; 0 clears both flags |
| tol_mv_i | input | 8 | Tolerance window width in mV |
| noise_i | input | 16 | Injected noise magnitude in mV |
| usage_i | input | 35 | Five 7-bit engine load percentages, lane 0 in bits 6:0 |
| over_o | output | 1 | Sticky over-voltage flag |
| under_o | output | 1 | Sticky under-voltage flag |

## Verification
The properties assume the following about the inputs:

- all inputs are stable around each rising sampling edge;
- reset is released away from that edge.

The bench meets both assumptions:

- it changes every input a quarter period after a rising edge;
- it releases or asserts reset between edges.

Load lanes are allowed to carry values up to 127, so the saturation rule is exercised, not just the documented 0 to 100 range. A randomised phase keeps the noise close to the half-tolerance boundary and drives the nominal voltage to zero only occasionally. This lets set, hold and clear events follow one another.

// File: rtl/rail_mon_pkg.sv
package rail_mon_pkg;

  // Registered state of the two window flags.
  typedef struct packed {
    logic over;
    logic under;
  } rail_flags_t;

  // Width needed to hold values 0..max_val.
  function automatic int unsigned bits_for(input int unsigned max_val);
    int unsigned w;
    w = 1;
    while ((1 << w) <= max_val) w++;
    return w;
  endfunction

endpackage

// File: rtl/rail_load_sum.sv
// Saturates each engine load lane and sums the lanes.
module rail_load_sum #(
  parameter int unsigned NUM_ENG   = 5,
  parameter int unsigned USAGE_W   = 7,
  parameter int unsigned USAGE_MAX = 100,
  parameter int unsigned SUM_W     = 9
) (
  input  logic [NUM_ENG*USAGE_W-1:0] usage_i,
  output logic [SUM_W-1:0]           sum_o
);

  localparam logic [USAGE_W-1:0] LANE_CAP = USAGE_W'(USAGE_MAX);

  logic [USAGE_W-1:0] lane_clamped [NUM_ENG];

  for (genvar k = 0; k < NUM_ENG; k++) begin : g_lane
    logic [USAGE_W-1:0] lane_raw;
    assign lane_raw        = usage_i[k*USAGE_W +: USAGE_W];
    assign lane_clamped[k] = (lane_raw > LANE_CAP) ? LANE_CAP : lane_raw;
  end

  always_comb begin
    sum_o = '0;
    for (int k = 0; k < NUM_ENG; k++) begin
      sum_o = sum_o + SUM_W'(lane_clamped[k]);
    end
  end

endmodule

// File: rtl/rail_noise_cmp.sv
// Flags noise that reaches past half of the tolerance window.
module rail_noise_cmp #(
  parameter int unsigned TOL_W   = 8,
  parameter int unsigned NOISE_W = 16
) (
  input  logic [TOL_W-1:0]   tol_i,
  input  logic [NOISE_W-1:0] noise_i,
  output logic               excess_o
);

  localparam int unsigned CMP_W = (TOL_W > NOISE_W) ? TOL_W : NOISE_W;

  logic [CMP_W-1:0] half_tol;
  logic [CMP_W-1:0] noise_ext;

  always_comb begin
    half_tol  = CMP_W'(tol_i >> 1);
    noise_ext = CMP_W'(noise_i);
    excess_o  = noise_ext > half_tol;
  end

endmodule

// File: rtl/rail_flag_reg.sv
// Sticky over/under flag storage; clear has priority over set.
module rail_flag_reg
  import rail_mon_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clear_i,
  input  logic        set_over_i,
  input  logic        set_under_i,
  output rail_flags_t flags_o
);

  rail_flags_t flags_q;
  rail_flags_t flags_d;
  logic        flags_en;

  always_comb begin
    flags_d  = flags_q;
    flags_en = 1'b0;
    if (clear_i) begin
      flags_d  = '0;
      flags_en = flags_q.over | flags_q.under;
    end else begin
      if (set_over_i && !flags_q.over) begin
        flags_d.over = 1'b1;
        flags_en     = 1'b1;
      end
      if (set_under_i && !flags_q.under) begin
        flags_d.under = 1'b1;
        flags_en      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;

endmodule

// File: rtl/rail_window_monitor.sv
module rail_window_monitor
  import rail_mon_pkg::*;
#(
  parameter int unsigned NUM_ENG   = 5,
  parameter int unsigned USAGE_W   = 7,
  parameter int unsigned USAGE_MAX = 100,
  parameter int unsigned LOAD_PCT  = 70,
  parameter int unsigned REF_W     = 16,
  parameter int unsigned TOL_W     = 8,
  parameter int unsigned NOISE_W   = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [REF_W-1:0]           ref_mv_i,
  input  logic [TOL_W-1:0]           tol_mv_i,
  input  logic [NOISE_W-1:0]         noise_i,
  input  logic [NUM_ENG*USAGE_W-1:0] usage_i,
  output logic                       over_o,
  output logic                       under_o
);

  // Average over LOAD_PCT is checked as sum over LOAD_PCT*NUM_ENG.
  localparam int unsigned LOAD_LIMIT = LOAD_PCT * NUM_ENG;
  localparam int unsigned SUM_MAX    = USAGE_MAX * NUM_ENG;
  localparam int unsigned SUM_W      =
    bits_for((SUM_MAX > LOAD_LIMIT) ? SUM_MAX : LOAD_LIMIT);
  localparam logic [SUM_W-1:0] LIMIT_V = SUM_W'(LOAD_LIMIT);

  logic [SUM_W-1:0] load_sum;
  logic             noise_excess;
  logic             load_heavy;
  logic             ref_zero;
  rail_flags_t      flags;

  rail_load_sum #(
    .NUM_ENG  (NUM_ENG),
    .USAGE_W  (USAGE_W),
    .USAGE_MAX(USAGE_MAX),
    .SUM_W    (SUM_W)
  ) u_load_sum (
    .usage_i(usage_i),
    .sum_o  (load_sum)
  );

  rail_noise_cmp #(
    .TOL_W  (TOL_W),
    .NOISE_W(NOISE_W)
  ) u_noise_cmp (
    .tol_i   (tol_mv_i),
    .noise_i (noise_i),
    .excess_o(noise_excess)
  );

  assign load_heavy = load_sum > LIMIT_V;
  assign ref_zero   = (ref_mv_i == '0);

  rail_flag_reg u_flag_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (ref_zero),
    .set_over_i (noise_excess),
    .set_under_i(noise_excess | load_heavy),
    .flags_o    (flags)
  );

  assign over_o  = flags.over;
  assign under_o = flags.under;

endmodule

// File: rtl/rail_window_monitor_chk.sv
module rail_window_monitor_chk #(
  parameter int unsigned REF_W   = 16,
  parameter int unsigned TOL_W   = 8,
  parameter int unsigned NOISE_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [REF_W-1:0]   ref_mv_i,
  input logic [TOL_W-1:0]   tol_mv_i,
  input logic [NOISE_W-1:0] noise_i,
  input logic               over_o,
  input logic               under_o
);

  logic [NOISE_W+TOL_W-1:0] half_ext;
  logic [NOISE_W+TOL_W-1:0] noise_ext;
  assign half_ext  = (NOISE_W+TOL_W)'(tol_mv_i >> 1);
  assign noise_ext = (NOISE_W+TOL_W)'(noise_i);

  // R1: flags held low while reset is active
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_low: assert (!over_o && !under_o);
    end
  end

  a_r8_zero_ref_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_mv_i == '0) |=> (!over_o && !under_o));

  a_r7_over_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (over_o && ref_mv_i != '0) |=> over_o);

  a_r7_under_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (under_o && ref_mv_i != '0) |=> under_o);

  a_r2_noise_sets_over: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_mv_i != '0 && noise_ext > half_ext) |=> over_o);

  a_r3_noise_sets_under: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_mv_i != '0 && noise_ext > half_ext) |=> under_o);

  a_r4_quiet_keeps_over_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!over_o && noise_ext <= half_ext) |=> !over_o);

  a_r9_over_implies_under: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_o |-> under_o);

endmodule

bind rail_window_monitor rail_window_monitor_chk #(
  .REF_W  (REF_W),
  .TOL_W  (TOL_W),
  .NOISE_W(NOISE_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ref_mv_i(ref_mv_i),
  .tol_mv_i(tol_mv_i),
  .noise_i (noise_i),
  .over_o  (over_o),
  .under_o (under_o)
);

// File: tb/rail_window_monitor_bench.sv
module rail_window_monitor_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [15:0] ref_mv_i;
  logic [7:0]  tol_mv_i;
  logic [15:0] noise_i;
  logic [34:0] usage_i;
  logic        over_o;
  logic        under_o;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string cur_req = "R1";

  bit m_over;
  bit m_under;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rail_window_monitor u_rail_window_monitor (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ref_mv_i(ref_mv_i),
    .tol_mv_i(tol_mv_i),
    .noise_i (noise_i),
    .usage_i (usage_i),
    .over_o  (over_o),
    .under_o (under_o)
  );

  // Behavioural reference model.
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_over  <= 0;
      m_under <= 0;
    end else begin
      int total;
      total = 0;
      for (int k = 0; k < 5; k++) begin
        int v;
        v = int'(usage_i[k*7 +: 7]);
        total += (v > 100) ? 100 : v;
      end
      if (ref_mv_i == 0) begin
        m_over  <= 0;
        m_under <= 0;
      end else begin
        if (int'(noise_i) > int'(tol_mv_i) / 2) begin
          m_over  <= 1;
          m_under <= 1;
        end
        if (total > 350) m_under <= 1;
      end
    end
  end

  task automatic check_now();
    n_tests++;
    if (over_o !== m_over || under_o !== m_under) begin
      n_fail++;
      $display("FAIL %s: over/under actual %b%b expected %b%b at %0t",
               cur_req, over_o, under_o, m_over, m_under, $time);
    end
  endtask

  // Compare on every falling edge.
  always @(negedge clk_i) begin
    if (!done) check_now();
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      #(CLK_PERIOD/4);
    end
  endtask

  task automatic set_usage(input int u0, u1, u2, u3, u4);
    usage_i = {7'(u4), 7'(u3), 7'(u2), 7'(u1), 7'(u0)};
  endtask

  task automatic expect_flags(input string req, input bit eo, input bit eu);
    n_tests++;
    if (over_o !== eo || under_o !== eu) begin
      n_fail++;
      $display("FAIL %s: over/under actual %b%b expected %b%b", req,
               over_o, under_o, eo, eu);
    end
  endtask

  initial begin
    rst_ni   = 1'b0;
    ref_mv_i = 16'd3300;
    tol_mv_i = 8'd20;
    noise_i  = '0;
    set_usage(10, 10, 10, 10, 10);
    #1;
    expect_flags("R1", 0, 0);
    step(3);
    rst_ni = 1'b1;
    step(3);
    expect_flags("R1", 0, 0);

    // Boundary: noise equal to truncated half of 9 (R4)
    cur_req  = "R4";
    tol_mv_i = 8'd9;
    noise_i  = 16'd4;
    step(3);
    expect_flags("R4", 0, 0);

    // Noise above half sets both flags (R2, R3)
    cur_req = "R2";
    noise_i = 16'd5;
    step(1);
    expect_flags("R2", 1, 1);
    expect_flags("R3", 1, 1);

    // Cause removed, flags hold (R7)
    cur_req = "R7";
    noise_i = '0;
    step(4);
    expect_flags("R7", 1, 1);

    // Zero reference clears, even with noise high (R8)
    cur_req  = "R8";
    ref_mv_i = '0;
    noise_i  = 16'd200;
    step(1);
    expect_flags("R8", 0, 0);
    noise_i  = '0;
    ref_mv_i = 16'd1800;
    step(2);
    expect_flags("R8", 0, 0);

    // Load: sum 350 sets nothing, 351 sets under only (R5)
    cur_req = "R5";
    set_usage(70, 70, 70, 70, 70);
    step(3);
    expect_flags("R5", 0, 0);
    set_usage(71, 70, 70, 70, 70);
    step(1);
    expect_flags("R5", 0, 1);
    set_usage(0, 0, 0, 0, 0);
    step(2);
    expect_flags("R7", 0, 1);

    cur_req  = "R8";
    ref_mv_i = '0;
    step(1);
    expect_flags("R8", 0, 0);
    ref_mv_i = 16'd1200;

    // Saturation: 127 counts as 100 -> 100+4*60 = 340 (R6)
    cur_req = "R6";
    set_usage(127, 60, 60, 60, 60);
    step(3);
    expect_flags("R6", 0, 0);
    set_usage(60, 60, 60, 60, 127);
    step(2);
    expect_flags("R6", 0, 0);
    set_usage(127, 127, 127, 127, 127);
    step(1);
    expect_flags("R6", 0, 1);

    // Asynchronous reset mid-run (R1)
    cur_req = "R1";
    noise_i = 16'd50;
    step(1);
    @(negedge clk_i);
    #1;
    rst_ni = 1'b0;
    #1;
    expect_flags("R1", 0, 0);
    noise_i = '0;
    set_usage(0, 0, 0, 0, 0);
    step(2);
    rst_ni = 1'b1;
    step(2);
    expect_flags("R1", 0, 0);

    // Randomised mix near the boundaries (R9 and all others)
    cur_req = "R9";
    for (int i = 0; i < 400; i++) begin
      tol_mv_i = 8'($urandom_range(0, 40));
      noise_i  = 16'($urandom_range(0, 22));
      ref_mv_i = ($urandom_range(0, 15) == 0) ? 16'd0 : 16'($urandom_range(1, 5000));
      set_usage($urandom_range(40, 127), $urandom_range(40, 127),
                $urandom_range(40, 127), $urandom_range(40, 127),
                $urandom_range(40, 127));
      step(1);
      if (over_o && !under_o) begin
        n_tests++;
        n_fail++;
        $display("FAIL R9: over/under actual %b%b expected under set", over_o, under_o);
      end
    end

    step(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule